// File: doc/BRIEF.md
# MDIO Management Master (Clause 22 and Clause 45)

This block is a station-management master. It produces MDC and the MDIO frames that read and write registers in Ethernet PHYs. Software controls it through one 32-bit command register on a simple write-strobe port. A single word selects the whole frame: the start code, the opcode, the port address, the register or device address and the 16-bit payload. If the go bit is set, writing the word launches exactly one frame. The go bit reads back as busy until the frame has ended. After a read frame, the returned data sits in the low half of the same register.

The block places the start code and the opcode on the wire exactly as written, so one register covers both frame families. Start code 01 gives a Clause 22 frame, with opcode 01 for a write and 10 for a read. Start code 00 gives a Clause 45 frame, with opcode 00 for an address frame, 01 for a write and 11 for a read. A Clause 45 access takes two commands. The first is an address frame, which carries the register address in its 16-bit field. The second is a write or read frame to the same port and device. Software waits for busy to drop before it issues the next command.

A sequencer walks through the frame with these states: `ST_IDLE`, `ST_PRE` (32 preamble ones), `ST_HDR` (start, opcode, port, register/device), `ST_TA` (turnaround), `ST_DAT` (16 data bits) and `ST_FIN` (wait for the last MDC fall). Transitions:
- `ST_IDLE`→`ST_PRE` on an accepted go write.
- `ST_PRE`→`ST_HDR` after the 32nd rising MDC edge.
- `ST_HDR`→`ST_TA` after bit 45.
- `ST_TA`→`ST_DAT` after bit 47.
- `ST_DAT`→`ST_FIN` after bit 63.
- `ST_FIN`→`ST_IDLE` on the falling MDC edge that follows.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the command register reads 0, MDC is low and MDIO is released (`mdio_oe`=0).
- R2: A write while idle stores the whole word. If bit 31 is 1, a frame starts and bit 31 reads 1 from the next cycle until completion. If bit 31 is 0, nothing is sent and MDC stays low.
- R3: Every frame is 64 MDC cycles, each field sent MSB first, in this order:
  - 32 ones;
  - start code (bits 17:16);
  - opcode (bits 19:18);
  - port address (bits 24:20);
  - register/device address (bits 29:25);
  - turnaround;
  - 16 bits from bits 15:0.
- R4: Clause 22 frames use start code 01, with opcode 01 for a write and 10 for a read. The fields appear on the wire unchanged.
- R5: Clause 45 frames use start code 00, with opcode 00 for an address frame (16-bit register address in the data field), 01 for a write and 11 for a read. Both frames of a pair carry the same port and device fields.
- R6: When opcode bit 19 is 0 (write or address), the master drives the turnaround as 1 then 0 and drives all 16 data bits.
- R7: When opcode bit 19 is 1 (read), the master releases MDIO for both turnaround bits and the 16 data bits. It samples `mdio_i` on each rising MDC edge of the data field, MSB first.
- R8: MDC stays high for N system cycles and low for N system cycles, where N is `mdc_half` and a value of 0 counts as 1. MDC is low while idle. MDIO changes only in the cycle MDC rises.
- R9: Busy clears on the falling MDC edge after the 64th rise. A read frame loads its sampled data into bits 15:0 in that same cycle. A write or address frame leaves bits 15:0 as written.
- R10: A write while busy is ignored, and this includes a write in the very cycle the frame completes. The register fields and the frame on the wire stay unchanged, and no second frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdc_half | input | DIV_W | MDC half-period in system cycles (0 acts as 1) |
| reg_wr | input | 1 | Command register write strobe |
| reg_wdata | input | 32 | Command word |
| reg_rdata | output | 32 | Command register readback (bit 31 busy, 15:0 read data) |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
Two events can fall in one cycle: a frame completing, and software writing a new command. The bench counts system cycles from the launch of a Clause 22 read and presents a go write exactly on the edge where MDC falls for the last time. It then expects busy to be clear, the read data to be loaded and the stored fields to be unchanged. It also expects MDC to stay low afterwards, with no extra frame reaching the scoreboard. A second case writes in the middle of a frame and judges the result the same way.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_LEN = 64;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam int DATA_W    = 16;
    localparam int PRE_LEN   = 32;
    localparam int HDR_LEN   = 14;
    localparam int TA_LEN    = 2;

    localparam logic [IDX_W-1:0] PRE_LAST = IDX_W'(PRE_LEN - 1);
    localparam logic [IDX_W-1:0] HDR_LAST = IDX_W'(PRE_LEN + HDR_LEN - 1);
    localparam logic [IDX_W-1:0] TA_LAST  = IDX_W'(PRE_LEN + HDR_LEN + TA_LEN - 1);
    localparam logic [IDX_W-1:0] DAT_LAST = IDX_W'(FRAME_LEN - 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TA,
        ST_DAT,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic              go;
        logic              spare;
        logic [4:0]        dev;
        logic [4:0]        port;
        logic [1:0]        op;
        logic [1:0]        st;
        logic [DATA_W-1:0] data;
    } cmd_word_t;

    function automatic logic [FRAME_LEN-1:0] build_frame(input cmd_word_t c);
        return {{PRE_LEN{1'b1}}, c.st, c.op, c.port, c.dev, 2'b10, c.data};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] half,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);

    localparam logic [DIV_W-1:0] CNT_ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] limit;
    logic             mdc_q;
    logic             tick;

    always_comb begin
        limit = (half == '0) ? '0 : (half - CNT_ONE);
        tick  = en && (cnt_q == limit);
        rise  = tick && !mdc_q;
        fall  = tick && mdc_q;
        mdc   = mdc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!en) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    // R8: clock parked low whenever no frame runs
    a_r8_mdc_parked_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !mdc_q);

    // R8: MDC only moves on a divider tick
    a_r8_mdc_holds_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(mdc_q));

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  cmd_word_t         cmd,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              active,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdio_o,
    output logic              mdio_oe
);

    seq_state_e            state_q, state_d;
    logic [IDX_W-1:0]      idx_q, idx_d;
    logic [FRAME_LEN-1:0]  frame_q;
    logic                  is_read_q;
    logic [DATA_W-1:0]     shift_q;
    logic                  cur_bit;

    assign cur_bit = frame_q[IDX_W'(FRAME_LEN - 1) - idx_q];

    // next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_PRE;
                    idx_d   = '0;
                end
            end
            ST_PRE: begin
                if (rise) begin
                    idx_d = idx_q + 1'b1;
                    if (idx_q == PRE_LAST) state_d = ST_HDR;
                end
            end
            ST_HDR: begin
                if (rise) begin
                    idx_d = idx_q + 1'b1;
                    if (idx_q == HDR_LAST) state_d = ST_TA;
                end
            end
            ST_TA: begin
                if (rise) begin
                    idx_d = idx_q + 1'b1;
                    if (idx_q == TA_LAST) state_d = ST_DAT;
                end
            end
            ST_DAT: begin
                if (rise) begin
                    idx_d = idx_q + 1'b1;
                    if (idx_q == DAT_LAST) state_d = ST_FIN;
                end
            end
            ST_FIN: begin
                if (fall) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            idx_q     <= '0;
            frame_q   <= '0;
            is_read_q <= 1'b0;
            shift_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (state_q == ST_IDLE && start) begin
                frame_q   <= build_frame(cmd);
                is_read_q <= cmd.op[1];
            end
            if (state_q == ST_DAT && rise && is_read_q) begin
                shift_q <= {shift_q[DATA_W-2:0], mdio_i};
            end
        end
    end

    // outputs
    always_comb begin
        mdio_o  = 1'b0;
        mdio_oe = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_FIN: begin
                mdio_o  = 1'b0;
                mdio_oe = 1'b0;
            end
            ST_PRE, ST_HDR: begin
                mdio_o  = cur_bit;
                mdio_oe = 1'b1;
            end
            ST_TA, ST_DAT: begin
                mdio_oe = !is_read_q;
                mdio_o  = is_read_q ? 1'b0 : cur_bit;
            end
            default: begin
                mdio_o  = 1'b0;
                mdio_oe = 1'b0;
            end
        endcase
        active  = (state_q != ST_IDLE);
        done    = (state_q == ST_FIN) && fall;
        rd_data = shift_q;
    end

    // R7: master off the line during a read turnaround and data field
    a_r7_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_TA || state_q == ST_DAT) && is_read_q) |-> !mdio_oe);

    // R6: write turnaround is driven 1 then 0
    a_r6_ta_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TA && !is_read_q) |-> (mdio_oe && (mdio_o == (idx_q == HDR_LAST + 1'b1))));

    // R8: line only moves together with a rising MDC edge
    a_r8_mdio_moves_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && state_q != ST_FIN && $past(state_q) != ST_IDLE && !$stable(mdio_o))
            |-> $past(rise));

    // R3: preamble is all ones
    a_r3_preamble_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRE) |-> (mdio_oe && mdio_o));

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] mdc_half,
    input  logic             reg_wr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             mdc,
    input  logic             mdio_i,
    output logic             mdio_o,
    output logic             mdio_oe
);

    cmd_word_t         cmd_q;
    cmd_word_t         wr_cmd;
    logic              busy;
    logic              accept;
    logic              start;
    logic              active;
    logic              done;
    logic              rise;
    logic              fall;
    logic [DATA_W-1:0] rd_data;

    always_comb begin
        wr_cmd    = cmd_word_t'(reg_wdata);
        busy      = cmd_q.go;
        accept    = reg_wr && !busy;
        start     = accept && wr_cmd.go;
        reg_rdata = 32'(cmd_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (accept) begin
            cmd_q <= wr_cmd;
        end else if (done) begin
            cmd_q.go <= 1'b0;
            if (cmd_q.op[1]) cmd_q.data <= rd_data;
        end
    end

    mdio_mdc_gen #(.DIV_W(DIV_W)) i_clkgen (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (active),
        .half (mdc_half),
        .mdc  (mdc),
        .rise (rise),
        .fall (fall)
    );

    mdio_frame_seq i_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .cmd    (wr_cmd),
        .rise   (rise),
        .fall   (fall),
        .mdio_i (mdio_i),
        .active (active),
        .done   (done),
        .rd_data(rd_data),
        .mdio_o (mdio_o),
        .mdio_oe(mdio_oe)
    );

    // R10: fields frozen while a frame is in flight
    a_r10_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cmd_q[30:16]));

    // R2: accepted go write raises busy
    a_r2_launch_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R9: busy drops only on frame completion
    a_r9_clear_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_q.go) |-> $past(done));

    // R2: busy and the sequencer agree
    a_r2_busy_tracks_seq: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> active);

endmodule

// File: tb/test_mdio_mgmt_master.sv
module test_mdio_mgmt_master;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [63:0] bits;
        logic [63:0] oe;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mdc_half = 8'd2;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc;
    logic        mdio_i = 1'b1;
    logic        mdio_o;
    logic        mdio_oe;

    int total = 0;
    int bad = 0;
    int cur_h = 2;
    logic [15:0] rd_pattern = '0;
    item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_mgmt_master i_mdio_mgmt_master (
        .clk      (clk),
        .rst_n    (rst_n),
        .mdc_half (mdc_half),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .mdc      (mdc),
        .mdio_i   (mdio_i),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic item_t mk_item(input logic [31:0] w, input string tag);
        item_t it;
        it.bits = {32'hFFFF_FFFF, w[17:16], w[19:18], w[24:20], w[29:25], 2'b10, w[15:0]};
        it.oe   = w[19] ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
        it.tag  = tag;
        return it;
    endfunction

    // monitor: captures the line at each MDC rise, checks MDC phases, models the PHY
    int          fidx = 0;
    int          run = 0;
    logic        prev_mdc = 1'b0;
    logic        prev_o = 1'b0;
    logic        prev_oe = 1'b0;
    logic [63:0] cap_bits = '0;
    logic [63:0] cap_oe = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mdc && !prev_mdc) begin
                cap_bits[63-fidx] = prev_o;
                cap_oe[63-fidx]   = prev_oe;
                if (fidx != 0) chk(run == cur_h, "R8 low phase", 64'(run), 64'(cur_h));
                fidx++;
                run = 1;
                if (fidx == 64) begin
                    fidx = 0;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R10 unexpected frame", cap_bits, 64'd0);
                    end else begin
                        item_t it;
                        it = exp_q.pop_front();
                        chk(((cap_bits ^ it.bits) & it.oe) == 64'd0, {it.tag, " bits"}, cap_bits, it.bits);
                        chk(cap_oe == it.oe, {it.tag, " enable"}, cap_oe, it.oe);
                    end
                end
            end else if (!mdc && prev_mdc) begin
                chk(run == cur_h, "R8 high phase", 64'(run), 64'(cur_h));
                run = 1;
            end else begin
                run++;
            end
            prev_mdc = mdc;
            prev_o   = mdio_o;
            prev_oe  = mdio_oe;
            mdio_i   = (fidx >= 48) ? rd_pattern[63-fidx] : 1'b1;
        end
    end

    task automatic launch(input logic [31:0] w, input int h, input logic [15:0] pat, input string tag);
        @(negedge clk);
        mdc_half   = h[7:0];
        cur_h      = (h == 0) ? 1 : h;
        rd_pattern = pat;
        if (w[31]) exp_q.push_back(mk_item(w, tag));
        reg_wr    = 1'b1;
        reg_wdata = w;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        if (w[31]) chk(reg_rdata[31] == 1'b1, "R2 busy after launch", 64'(reg_rdata), 64'(w));
    endtask

    task automatic wait_idle();
        while (reg_rdata[31]) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic run_frame(input logic [31:0] w, input int h, input logic [15:0] pat, input string tag);
        launch(w, h, pat, tag);
        wait_idle();
        chk(reg_rdata[31:16] == {1'b0, w[30:16]}, {tag, " R9 fields kept"}, 64'(reg_rdata), 64'(w));
        if (w[19]) chk(reg_rdata[15:0] == pat, {tag, " R9 read data"}, 64'(reg_rdata[15:0]), 64'(pat));
        else       chk(reg_rdata[15:0] == w[15:0], {tag, " R9 data kept"}, 64'(reg_rdata[15:0]), 64'(w[15:0]));
        chk(exp_q.size() == 0, {tag, " R3 frame seen"}, 64'(exp_q.size()), 64'd0);
    endtask

    function automatic logic [31:0] cmd(input logic [1:0] st, input logic [1:0] op,
                                        input logic [4:0] port, input logic [4:0] dev,
                                        input logic [15:0] d);
        return {1'b1, 1'b0, dev, port, op, st, d};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 64'd0, 64'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] w;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(reg_rdata == 32'd0, "R1 register", 64'(reg_rdata), 64'd0);
        chk(mdc == 1'b0, "R1 mdc", 64'(mdc), 64'd0);
        chk(mdio_oe == 1'b0, "R1 oe", 64'(mdio_oe), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4 R6: clause 22 write
        run_frame(cmd(2'b01, 2'b01, 5'h03, 5'h0D, 16'hA5C3), 2, 16'h0000, "R4 R6 c22 write");
        // R4 R7: clause 22 read
        run_frame(cmd(2'b01, 2'b10, 5'h1F, 5'h02, 16'h0000), 3, 16'h1357, "R4 R7 c22 read");
        // R5 R8: clause 45 address frame, divider 0 acts as 1
        run_frame(cmd(2'b00, 2'b00, 5'h07, 5'h1E, 16'h4001), 0, 16'h0000, "R5 R8 c45 address");
        // R5 R6: clause 45 write
        run_frame(cmd(2'b00, 2'b01, 5'h07, 5'h1E, 16'hBEEF), 4, 16'h0000, "R5 R6 c45 write");
        // R5 R7: clause 45 address then read
        run_frame(cmd(2'b00, 2'b00, 5'h11, 5'h01, 16'h8000), 2, 16'h0000, "R5 c45 address");
        run_frame(cmd(2'b00, 2'b11, 5'h11, 5'h01, 16'h0000), 5, 16'hC0DE, "R5 R7 c45 read");

        // R2: store without go
        launch(32'h0ABC_1234, 2, 16'h0, "R2 no go");
        chk(reg_rdata == 32'h0ABC_1234, "R2 stored word", 64'(reg_rdata), 64'h0ABC_1234);
        repeat (30) @(negedge clk);
        chk(mdc == 1'b0, "R2 no frame from store", 64'(mdc), 64'd0);

        // R10: write in the middle of a frame
        w = cmd(2'b01, 2'b01, 5'h05, 5'h09, 16'h6A6A);
        launch(w, 2, 16'h0, "R10 mid-frame");
        repeat (40) @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = cmd(2'b00, 2'b11, 5'h1A, 5'h15, 16'h1111);
        @(negedge clk);
        reg_wr = 1'b0;
        chk(reg_rdata == w, "R10 fields unchanged", 64'(reg_rdata), 64'(w));
        wait_idle();
        chk(reg_rdata == {1'b0, w[30:0]}, "R10 after frame", 64'(reg_rdata), 64'({1'b0, w[30:0]}));
        repeat (30) @(negedge clk);
        chk(mdc == 1'b0 && exp_q.size() == 0, "R10 no second frame", 64'(mdc), 64'd0);

        // R9 R10: write in the completion cycle of a read
        w = cmd(2'b01, 2'b10, 5'h02, 5'h04, 16'h0000);
        launch(w, 2, 16'h9C3B, "R9 R10 boundary read");
        repeat (128*2 - 1) @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = cmd(2'b01, 2'b01, 5'h1B, 5'h1C, 16'hFFFF);
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        chk(reg_rdata == {1'b0, w[30:16], 16'h9C3B}, "R9 R10 completion cycle",
            64'(reg_rdata), 64'({1'b0, w[30:16], 16'h9C3B}));
        repeat (30) @(negedge clk);
        chk(mdc == 1'b0 && exp_q.size() == 0, "R10 no frame from completion write", 64'(mdc), 64'd0);

        // R2: accepted right after completion
        run_frame(cmd(2'b01, 2'b01, 5'h00, 5'h1F, 16'h0F0F), 1, 16'h0, "R2 R3 follow-up write");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule